// File: doc/BRIEF.md
# External Bus Master with Burst Instruction Fetch

This block masters the external memory bus of a 16-bit processor core. The core hands it one request at a time over a valid/ready handshake. A request is a single data read, a single data write, or an instruction fetch. The block turns the request into bus cycles on a 20-bit address bus and drives chip select, output enable, write strobe and the low and high byte-lane strobes. It samples a wait input on each rising clock edge to stretch a cycle. It returns each piece of read data with a one-cycle valid pulse, and it pulses done once the request has finished.

A strap input picks an 8-bit or a 16-bit data bus. The block samples it when it accepts a request. Instruction fetches always run as bursts. A burst steps through the low address bits and wraps inside its aligned 16-byte block. On a 16-bit bus the burst steps by one word. On an 8-bit bus it steps by one byte. After the last data phase of every request, the block spends one cycle with all strobes released and the address held. In that cycle done is high.

Top module: `ebus_master`

## Requirements
- R1: `req_ready_o` is high only while no transfer is in progress. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `bus_cs_o` is high in the cycle that follows that edge.
- R2: On a 16-bit bus, a read or write drives `bus_bl_o` from `req_be_i[0]` and `bus_bh_o` from `req_be_i[1]`, so a single-byte write asserts only its own lane. A fetch on a 16-bit bus asserts both lanes.
- R3: On an 8-bit bus, `bus_bl_o` is high during every data phase, whatever the address. `bus_bh_o` is never high on an 8-bit bus.
- R4: Op codes are 0 for read, 1 for write, 2 for fetch; code 3 behaves as a read. A read or write is one data phase. The fetch length `req_len_i` in bytes is first clamped to the range 2 to 16. A fetch then takes ceil(length/2) data phases on a 16-bit bus and length data phases on an 8-bit bus.
- R5: A fetch on a 16-bit bus starts at the request address with bit 0 cleared. Each following data phase adds one to address bits [3:1], wrapping modulo 8. Bits [19:4] stay constant.
- R6: A fetch on an 8-bit bus starts at the request address. Each following data phase adds one to address bits [3:0], wrapping modulo 16. Bits [19:4] stay constant.
- R7: If `bus_wait_i` is high at a rising edge during a data phase, that phase lasts one more clock. The strobes and the address stay unchanged, and no data is captured.
- R8: After the final data phase of any request, there is exactly one cycle in which `bus_cs_o`, `bus_oe_o`, `bus_we_o` and both lane strobes are low. In that cycle `bus_addr_o[19:1]` still holds the last data-phase address and `done_o` is high. `req_ready_o` is high in the cycle after it.
- R9: During a read or fetch data phase, `bus_oe_o` is high and `bus_we_o` and `bus_doe_o` are low. During a write data phase, `bus_we_o` and `bus_doe_o` are high, `bus_oe_o` is low, and `bus_dout_o` equals the write data.
- R10: At a rising edge that ends a read or fetch data phase (wait low), the block captures the read data. `rsp_valid_o` is high for the following cycle only. `rsp_data_o` then equals `bus_din_i` on a 16-bit bus, and `{8'h00, bus_din_i[7:0]}` on an 8-bit bus. A write produces no `rsp_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus16_i | input | 1 | 1 selects a 16-bit bus, 0 an 8-bit bus; sampled on accept |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_op_i | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_addr_i | input | 20 | Byte address |
| req_be_i | input | 2 | Byte lanes for 16-bit data accesses |
| req_wdata_i | input | 16 | Write data |
| req_len_i | input | 5 | Fetch length in bytes |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_data_o | output | 16 | Read data |
| done_o | output | 1 | Request complete pulse |
| bus_addr_o | output | 20 | External address |
| bus_cs_o | output | 1 | Chip select, active high |
| bus_oe_o | output | 1 | Output enable, active high |
| bus_we_o | output | 1 | Write strobe, active high |
| bus_bl_o | output | 1 | Low byte-lane strobe, active high |
| bus_bh_o | output | 1 | High byte-lane strobe, active high |
| bus_dout_o | output | 16 | Write data to the bus |
| bus_doe_o | output | 1 | Data driver enable |
| bus_din_i | input | 16 | Read data from the bus |
| bus_wait_i | input | 1 | Wait request, sampled on the rising edge |

## Verification
The hardest case to reach is a wait stall that lands in the middle of a fetch burst right where the address wraps inside the 16-byte block. Address, lanes and capture must then all hold across the extra cycles before the wrapped address appears. The stimulus gets there with directed fetches that start near the top of a block at full length on both bus widths. Random traffic then adds a wait on about a third of all data phases, capped at three stalls in a row, so that stalls fall on wrap points, on first and last beats, and just before the hold cycle.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FETCH = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_HOLD = 2'd2
  } st_e;
endpackage

// File: rtl/ebus_addr_gen.sv
module ebus_addr_gen #(
  parameter int ADDR_W = 20,
  parameter int BLK_W  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bus16_i,
  output logic [ADDR_W-1:0] next_o
);
  localparam logic [BLK_W-1:0] STEP8  = BLK_W'(1);
  localparam logic [BLK_W-1:0] STEP16 = BLK_W'(2);

  logic [BLK_W-1:0] low;

  // wraps inside the aligned block; upper bits untouched
  always_comb begin
    low    = addr_i[BLK_W-1:0] + (bus16_i ? STEP16 : STEP8);
    next_o = {addr_i[ADDR_W-1:BLK_W], low};
  end
endmodule

// File: rtl/ebus_lane_map.sv
module ebus_lane_map (
  input  logic       bus16_i,
  input  logic       fetch_i,
  input  logic [1:0] be_i,
  output logic       bl_o,
  output logic       bh_o
);
  always_comb begin
    if (!bus16_i) begin
      bl_o = 1'b1;
      bh_o = 1'b0;
    end else if (fetch_i) begin
      bl_o = 1'b1;
      bh_o = 1'b1;
    end else begin
      bl_o = be_i[0];
      bh_o = be_i[1];
    end
  end
endmodule

// File: rtl/ebus_master.sv
module ebus_master
  import ebus_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int LEN_W     = 5,
  parameter int MIN_BURST = 2,
  parameter int MAX_BURST = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus16_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_cs_o,
  output logic              bus_oe_o,
  output logic              bus_we_o,
  output logic              bus_bl_o,
  output logic              bus_bh_o,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic              bus_doe_o,
  input  logic [DATA_W-1:0] bus_din_i,
  input  logic              bus_wait_i
);
  localparam int BLK_W = $clog2(MAX_BURST);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_BURST);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_BURST);

  st_e               st_q;
  op_e               op_q, op_in;
  logic              bus16_q;
  logic [ADDR_W-1:0] addr_q, addr_nxt, addr_start;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [LEN_W-1:0]  cnt_q, len_c, beats_m1;
  logic [LEN_W:0]    len_p1;
  logic              rvld_q;
  logic              accept, beat_end, is_wr, lane_bl, lane_bh;

  assign op_in  = op_e'(req_op_i);
  assign accept = req_valid_i && (st_q == ST_IDLE);

  always_comb begin
    if (req_len_i < LEN_MIN)      len_c = LEN_MIN;
    else if (req_len_i > LEN_MAX) len_c = LEN_MAX;
    else                          len_c = req_len_i;
    len_p1 = {1'b0, len_c} + 1'b1;
    if (op_in != OP_FETCH) beats_m1 = '0;
    else if (bus16_i)      beats_m1 = len_p1[LEN_W:1] - 1'b1;
    else                   beats_m1 = len_c - 1'b1;
    addr_start = req_addr_i;
    if (op_in == OP_FETCH && bus16_i) addr_start[0] = 1'b0;
  end

  assign beat_end = (st_q == ST_DATA) && !bus_wait_i;
  assign is_wr    = (op_q == OP_WRITE);

  ebus_addr_gen #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_addr (
    .addr_i (addr_q),
    .bus16_i(bus16_q),
    .next_o (addr_nxt)
  );

  ebus_lane_map u_lane (
    .bus16_i(bus16_q),
    .fetch_i(op_q == OP_FETCH),
    .be_i   (be_q),
    .bl_o   (lane_bl),
    .bh_o   (lane_bh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_READ;
      bus16_q <= 1'b1;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q    <= ST_DATA;
          op_q    <= op_in;
          bus16_q <= bus16_i;
          addr_q  <= addr_start;
          be_q    <= req_be_i;
          wdata_q <= req_wdata_i;
          cnt_q   <= beats_m1;
        end
        ST_DATA: if (beat_end) begin
          if (cnt_q == '0) begin
            st_q <= ST_HOLD;
          end else begin
            cnt_q  <= cnt_q - 1'b1;
            addr_q <= addr_nxt;
          end
        end
        ST_HOLD: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // capture only on the edge that closes an unstalled read phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvld_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      rvld_q <= beat_end && !is_wr;
      if (beat_end && !is_wr)
        rdata_q <= bus16_q ? bus_din_i : {{(DATA_W-8){1'b0}}, bus_din_i[7:0]};
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = rvld_q;
  assign rsp_data_o  = rdata_q;
  assign done_o      = (st_q == ST_HOLD);
  assign bus_addr_o  = addr_q;
  assign bus_cs_o    = (st_q == ST_DATA);
  assign bus_oe_o    = bus_cs_o && !is_wr;
  assign bus_we_o    = bus_cs_o && is_wr;
  assign bus_doe_o   = bus_we_o;
  assign bus_dout_o  = wdata_q;
  assign bus_bl_o    = bus_cs_o && lane_bl;
  assign bus_bh_o    = bus_cs_o && lane_bh;

  p_ready_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !bus_cs_o);
  p_start_cs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> bus_cs_o);
  p_lane_8bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cs_o && !bus16_q) |-> (bus_bl_o && !bus_bh_o));
  p_blk_const_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cs_o && $past(bus_cs_o)) |-> (bus_addr_o[ADDR_W-1:BLK_W] == $past(bus_addr_o[ADDR_W-1:BLK_W])));
  p_wait_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cs_o && bus_wait_i) |=> (bus_cs_o && $stable(bus_addr_o) && !rsp_valid_o));
  p_hold_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_cs_o) |-> ($stable(bus_addr_o[ADDR_W-1:1]) && done_o));
  p_no_drive_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> !bus_doe_o);
  p_rsp_after_beat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(bus_cs_o && !bus_wait_i && bus_oe_o));
endmodule

// File: tb/sim_ebus_master.sv
module sim_ebus_master;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus16_i = 1'b1;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [1:0]  req_op_i = '0;
  logic [19:0] req_addr_i = '0;
  logic [1:0]  req_be_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [4:0]  req_len_i = '0;
  logic        rsp_valid_o;
  logic [15:0] rsp_data_o;
  logic        done_o;
  logic [19:0] bus_addr_o;
  logic        bus_cs_o, bus_oe_o, bus_we_o, bus_bl_o, bus_bh_o, bus_doe_o;
  logic [15:0] bus_dout_o;
  logic [15:0] bus_din_i;
  logic        bus_wait_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  function automatic logic [15:0] mem(input logic [19:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] + a[7:0] + {4'h0, a[19:16]}};
  endfunction

  assign bus_din_i = mem(bus_addr_o);

  ebus_master u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int n_beats(input int op, input int len, input bit b16);
    int l;
    if (op != 2) return 1;
    l = (len < 2) ? 2 : ((len > 16) ? 16 : len);
    return b16 ? (l + 1) / 2 : l;
  endfunction

  function automatic logic [19:0] beat_addr(input int op, input logic [19:0] a, input bit b16, input int i);
    logic [19:0] b;
    if (op != 2) return a;
    b = a;
    if (b16) b[0] = 1'b0;
    b[3:0] = b[3:0] + 4'(b16 ? 2 * i : i);
    return b;
  endfunction

  task automatic xfer(input int op, input logic [19:0] a, input logic [1:0] be,
                      input logic [15:0] wd, input int len, input bit b16, input int wp);
    int nb;
    bit w;
    int stalls;
    logic [19:0] ea;
    logic [1:0] lanes;
    bit wr;
    nb = n_beats(op, len, b16);
    wr = (op == 1);
    lanes = !b16 ? 2'b01 : ((op == 2) ? 2'b11 : be);
    @(negedge clk_i);
    chk("R1 ready idle", req_ready_o, 1);
    bus16_i = b16; req_op_i = 2'(op); req_addr_i = a; req_be_i = be;
    req_wdata_i = wd; req_len_i = 5'(len); req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R1 busy", req_ready_o, 0);
    ea = a;
    for (int i = 0; i < nb; i++) begin
      ea = beat_addr(op, a, b16, i);
      stalls = 0;
      do begin
        w = (stalls < 3) && (($urandom % 100) < wp);
        bus_wait_i = w;
        chk("R1 cs in phase", bus_cs_o, 1);
        chk((op == 2) ? (b16 ? "R5 addr" : "R6 addr") : "R4 addr", bus_addr_o, ea);
        chk(b16 ? "R2 lanes" : "R3 lanes", {bus_bh_o, bus_bl_o}, lanes);
        chk("R9 oe/we/doe", {bus_oe_o, bus_we_o, bus_doe_o}, wr ? 3'b011 : 3'b100);
        if (wr) chk("R9 dout", bus_dout_o, wd);
        chk("R4 no early done", done_o, 0);
        @(negedge clk_i);
        if (w) begin
          chk("R7 no capture in stall", rsp_valid_o, 0);
          stalls++;
        end
      end while (w);
      bus_wait_i = 1'b0;
      if (wr) chk("R10 no rsp on write", rsp_valid_o, 0);
      else begin
        chk("R10 rsp valid", rsp_valid_o, 1);
        chk("R10 rsp data", rsp_data_o, b16 ? mem(ea) : {8'h00, mem(ea)[7:0]});
      end
    end
    chk("R8 strobes off", {bus_cs_o, bus_oe_o, bus_we_o, bus_bl_o, bus_bh_o}, 0);
    chk("R8 addr held", bus_addr_o[19:1], ea[19:1]);
    chk("R8 done", done_o, 1);
    @(negedge clk_i);
    chk("R8 done single", done_o, 0);
    chk("R8 ready after", req_ready_o, 1);
    chk("R10 rsp single", rsp_valid_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk("R1 reset ready", req_ready_o, 1);
    chk("R8 reset strobes", {bus_cs_o, bus_oe_o, bus_we_o, bus_bl_o, bus_bh_o, bus_doe_o}, 0);
    chk("R10 reset rsp", rsp_valid_o, 0);
    rst_ni = 1'b1;
    // directed corners
    xfer(2, 20'h1234D, 2'b11, 16'h0, 16, 1, 0);   // R5 wrap, odd start
    xfer(2, 20'hABCDF, 2'b11, 16'h0, 16, 0, 0);   // R6 wrap from top byte
    xfer(2, 20'h00104, 2'b11, 16'h0, 0, 1, 0);    // R4 clamp up
    xfer(2, 20'h00104, 2'b11, 16'h0, 31, 0, 0);   // R4 clamp down
    xfer(2, 20'h5555E, 2'b11, 16'h0, 3, 1, 0);    // R4 odd length on 16-bit
    xfer(1, 20'h00201, 2'b10, 16'hBEEF, 0, 1, 0); // R2 high byte only
    xfer(1, 20'h00200, 2'b01, 16'h1234, 0, 1, 0); // R2 low byte only
    xfer(1, 20'h00203, 2'b11, 16'h00C3, 0, 0, 0); // R3 write on 8-bit
    xfer(0, 20'hF0F0F, 2'b11, 16'h0, 0, 0, 0);    // R3 odd read 8-bit
    xfer(3, 20'h0A0A0, 2'b11, 16'h0, 0, 1, 0);    // R4 code 3 reads
    xfer(2, 20'h3333C, 2'b11, 16'h0, 16, 1, 100); // R7 stalls at wrap
    xfer(0, 20'h77777, 2'b11, 16'h0, 0, 1, 100);  // R7 read stall
    for (int k = 0; k < 80; k++) begin
      int op;
      op = int'($urandom % 4);
      xfer(op, 20'($urandom), 2'(($urandom % 3) + 1), 16'($urandom),
           int'($urandom % 32), 1'($urandom), 35);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule